// File: doc/BRIEF.md
# Storage Device Reset Sequencer

This controller steps a storage device through its reset and diagnostic flows and leaves it in idle. A line reset event forces it into a held-reset state from anywhere. When the line reset is released, it runs power-up self-test. The self-test result goes to the host as a status frame with a good or a bad code, and the block then becomes idle. From idle, the host can order a diagnostic run, which reports its result in the same way. The host can also order a device reset. That halts all activity, waits until the device is quiet, reports good status, and waits for the host's register frame before going back to idle.

The self-test routines and the frame contents are outside this block. Each of them is a handshake. `diag_run` asks for diagnostics, and `diag_done` with `diag_pass` returns the result. `stat_req` with `stat_code` asks the transmit side for a frame, and `stat_ack` completes that request. `host_frame` marks an incoming register frame from the host. All outputs are decoded from registered state, so each output responds one clock after the input that causes the change.

Top module: `devrst_sequencer`

## Requirements
- R1: After `rst_n` is released, the block is in the held-reset state: `idle`, `stat_req`, `diag_run`, `halt_req` and `done_pulse` are all 0.
- R2: A `line_rst` pulse in any state clears all four state outputs on the next cycle. They stay clear until `line_rel` is seen without `line_rst` in the same cycle, because `line_rst` takes priority.
- R3: `line_rel` in the held-reset state raises `diag_run` (power-up self-test) on the next cycle. `diag_run` then stays high until `diag_done` arrives.
- R4: `diag_done` during a diagnostic run raises `stat_req` on the next cycle. `stat_code` is 8'h01 when `diag_pass` is 1 and 8'h00 when it is 0.
- R5: `stat_req` and `stat_code` hold steady until `stat_ack`. On the cycle after an acknowledged pass or fail report, `stat_req` is 0 and `idle` is 1.
- R6: `done_pulse` is 1 for exactly the first cycle of every entry into idle.
- R7: `cmd_diag` in idle raises `diag_run` on the next cycle. The result is then reported as in R4 and R5.
- R8: `cmd_devrst` in idle raises `halt_req` on the next cycle and holds it until `quiesced`. After that comes `stat_req` with 8'h01, held until `stat_ack`. Then all outputs are low until `host_frame`, which gives idle on the next cycle. If `cmd_devrst` and `cmd_diag` arrive together, the device reset is taken.
- R9: `soft_rst` in idle, during a commanded diagnostic run, or anywhere in the device-reset path raises `halt_req` on the next cycle. This restarts the device-reset path.
- R10: `cmd_diag` and `cmd_devrst` have no effect outside idle: the outputs follow the sequence already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_rst | input | 1 | Line reset asserted event |
| line_rel | input | 1 | Line reset negated event |
| soft_rst | input | 1 | Software reset request |
| cmd_diag | input | 1 | Diagnose command strobe |
| cmd_devrst | input | 1 | Device reset command strobe |
| diag_done | input | 1 | Diagnostics finished |
| diag_pass | input | 1 | Diagnostic result, 1 = pass |
| quiesced | input | 1 | All device activity stopped |
| stat_ack | input | 1 | Status frame sent |
| host_frame | input | 1 | Register frame from host received |
| stat_req | output | 1 | Status frame request |
| stat_code | output | 8 | Status code, 8'h01 pass, 8'h00 fail |
| diag_run | output | 1 | Run diagnostics |
| halt_req | output | 1 | Halt all activity |
| idle | output | 1 | Block idle |
| done_pulse | output | 1 | One cycle on entry to idle |

## Verification
A wrong state register shows at the ports one cycle after the triggering input, because every output is a direct decode of the state. The bench compares the full output vector after every step.

Some mistakes can only be seen as a wrong choice between status states, such as reporting the wrong pass or fail result. These show up as a wrong `stat_code` in the first cycle of `stat_req`.

Mistakes in the post-reset wait or in the priority of `line_rst` show up as `idle` or `done_pulse` rising too early. The bench sweeps the handshake delays so that early exits cannot hide.

// File: rtl/devrst_pkg.sv
package devrst_pkg;
    parameter int CODE_W = 8;
    parameter logic [CODE_W-1:0] PASS_CODE = 8'h01;
    parameter logic [CODE_W-1:0] FAIL_CODE = 8'h00;

    typedef enum logic [3:0] {
        ST_HRST,
        ST_SELFTEST,
        ST_GOOD,
        ST_BAD,
        ST_IDLE,
        ST_DIAG,
        ST_HALT,
        ST_RGOOD,
        ST_RWAIT
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       done;
    } seq_regs_t;
endpackage

// File: rtl/devrst_next.sv
module devrst_next
    import devrst_pkg::*;
(
    input  seq_state_e cur,
    input  logic       line_rst,
    input  logic       line_rel,
    input  logic       soft_rst,
    input  logic       cmd_diag,
    input  logic       cmd_devrst,
    input  logic       diag_done,
    input  logic       diag_pass,
    input  logic       quiesced,
    input  logic       stat_ack,
    input  logic       host_frame,
    output seq_state_e nxt
);
    always_comb begin
        nxt = cur;
        if (line_rst) begin
            nxt = ST_HRST;
        end else begin
            case (cur)
                ST_HRST:     if (line_rel) nxt = ST_SELFTEST;
                ST_SELFTEST: if (diag_done) nxt = diag_pass ? ST_GOOD : ST_BAD;
                ST_GOOD,
                ST_BAD:      if (stat_ack) nxt = ST_IDLE;
                ST_IDLE: begin
                    if (cmd_devrst || soft_rst) nxt = ST_HALT;
                    else if (cmd_diag)          nxt = ST_DIAG;
                end
                ST_DIAG: begin
                    if (soft_rst)       nxt = ST_HALT;
                    else if (diag_done) nxt = diag_pass ? ST_GOOD : ST_BAD;
                end
                ST_HALT: begin
                    if (quiesced && !soft_rst) nxt = ST_RGOOD;
                end
                ST_RGOOD: begin
                    if (soft_rst)      nxt = ST_HALT;
                    else if (stat_ack) nxt = ST_RWAIT;
                end
                ST_RWAIT: begin
                    if (soft_rst)        nxt = ST_HALT;
                    else if (host_frame) nxt = ST_IDLE;
                end
                default: nxt = ST_HRST;
            endcase
        end
    end
endmodule

// File: rtl/devrst_outs.sv
module devrst_outs
    import devrst_pkg::*;
(
    input  seq_state_e        cur,
    output logic              stat_req,
    output logic [CODE_W-1:0] stat_code,
    output logic              diag_run,
    output logic              halt_req,
    output logic              idle
);
    always_comb begin
        stat_req  = (cur == ST_GOOD) || (cur == ST_BAD) || (cur == ST_RGOOD);
        stat_code = (cur == ST_GOOD || cur == ST_RGOOD) ? PASS_CODE : FAIL_CODE;
        diag_run  = (cur == ST_SELFTEST) || (cur == ST_DIAG);
        halt_req  = (cur == ST_HALT);
        idle      = (cur == ST_IDLE);
    end
endmodule

// File: rtl/devrst_sequencer.sv
module devrst_sequencer
    import devrst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_rst,
    input  logic              line_rel,
    input  logic              soft_rst,
    input  logic              cmd_diag,
    input  logic              cmd_devrst,
    input  logic              diag_done,
    input  logic              diag_pass,
    input  logic              quiesced,
    input  logic              stat_ack,
    input  logic              host_frame,
    output logic              stat_req,
    output logic [CODE_W-1:0] stat_code,
    output logic              diag_run,
    output logic              halt_req,
    output logic              idle,
    output logic              done_pulse
);
    seq_regs_t  regs_d, regs_q;
    seq_state_e nxt_state;

    devrst_next u_next (
        .cur        (regs_q.state),
        .line_rst   (line_rst),
        .line_rel   (line_rel),
        .soft_rst   (soft_rst),
        .cmd_diag   (cmd_diag),
        .cmd_devrst (cmd_devrst),
        .diag_done  (diag_done),
        .diag_pass  (diag_pass),
        .quiesced   (quiesced),
        .stat_ack   (stat_ack),
        .host_frame (host_frame),
        .nxt        (nxt_state)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = nxt_state;
        regs_d.done  = (nxt_state == ST_IDLE) && (regs_q.state != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= ST_HRST;
            regs_q.done  <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    devrst_outs u_outs (
        .cur       (regs_q.state),
        .stat_req  (stat_req),
        .stat_code (stat_code),
        .diag_run  (diag_run),
        .halt_req  (halt_req),
        .idle      (idle)
    );

    assign done_pulse = regs_q.done;
endmodule

// File: rtl/devrst_checker.sv
module devrst_checker
    import devrst_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              line_rst,
    input logic              soft_rst,
    input logic              quiesced,
    input logic              stat_ack,
    input logic              stat_req,
    input logic [CODE_W-1:0] stat_code,
    input logic              diag_run,
    input logic              halt_req,
    input logic              idle,
    input logic              done_pulse
);
    AST_LINE_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        line_rst |=> !idle && !stat_req && !diag_run && !halt_req); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stat_req && !stat_ack && !line_rst && !soft_rst |=> stat_req && $stable(stat_code)); // R5

    AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> idle); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R6

    AST_QUIET_TO_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req && quiesced && !line_rst && !soft_rst |=> stat_req && stat_code == PASS_CODE); // R8

    AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({idle, stat_req, diag_run, halt_req})); // R10
endmodule

bind devrst_sequencer devrst_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_rst   (line_rst),
    .soft_rst   (soft_rst),
    .quiesced   (quiesced),
    .stat_ack   (stat_ack),
    .stat_req   (stat_req),
    .stat_code  (stat_code),
    .diag_run   (diag_run),
    .halt_req   (halt_req),
    .idle       (idle),
    .done_pulse (done_pulse)
);

// File: tb/devrst_sequencer_test.sv
module devrst_sequencer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_rst = 0, line_rel = 0, soft_rst = 0, cmd_diag = 0, cmd_devrst = 0;
    logic diag_done = 0, diag_pass = 0, quiesced = 0, stat_ack = 0, host_frame = 0;
    logic       stat_req, diag_run, halt_req, idle, done_pulse;
    logic [7:0] stat_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    devrst_sequencer uut (
        .clk(clk), .rst_n(rst_n), .line_rst(line_rst), .line_rel(line_rel),
        .soft_rst(soft_rst), .cmd_diag(cmd_diag), .cmd_devrst(cmd_devrst),
        .diag_done(diag_done), .diag_pass(diag_pass), .quiesced(quiesced),
        .stat_ack(stat_ack), .host_frame(host_frame), .stat_req(stat_req),
        .stat_code(stat_code), .diag_run(diag_run), .halt_req(halt_req),
        .idle(idle), .done_pulse(done_pulse)
    );

    // observed vector: {idle, stat_req, diag_run, halt_req, done_pulse}
    localparam logic [4:0] O_NONE = 5'b00000;
    localparam logic [4:0] O_IDLE = 5'b10000;
    localparam logic [4:0] O_DONE = 5'b10001;
    localparam logic [4:0] O_STAT = 5'b01000;
    localparam logic [4:0] O_DIAG = 5'b00100;
    localparam logic [4:0] O_HALT = 5'b00010;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        line_rst = 0; line_rel = 0; soft_rst = 0; cmd_diag = 0; cmd_devrst = 0;
        diag_done = 0; diag_pass = 0; quiesced = 0; stat_ack = 0; host_frame = 0;
    endtask

    task automatic expect_out(string req, logic [4:0] exp_o, logic [7:0] exp_code, bit code_valid);
        logic [4:0] act_o;
        act_o = {idle, stat_req, diag_run, halt_req, done_pulse};
        n_checks++;
        if (act_o !== exp_o || (code_valid && stat_code !== exp_code)) begin
            n_fail++;
            $display("FAIL %s: outputs %b code %h, expected %b code %h",
                     req, act_o, stat_code, exp_o, exp_code);
        end
    endtask

    task automatic power_up(bit pass, int dly);
        clear_in(); line_rst = 1; tick(); clear_in();
        expect_out("R2", O_NONE, 8'h00, 0);
        line_rel = 1; tick(); clear_in();
        expect_out("R3", O_DIAG, 8'h00, 0);
        for (int i = 0; i < dly; i++) begin tick(); expect_out("R3", O_DIAG, 8'h00, 0); end
        diag_done = 1; diag_pass = pass; tick(); clear_in();
        expect_out("R4", O_STAT, pass ? 8'h01 : 8'h00, 1);
        for (int i = 0; i < dly; i++) begin
            tick(); expect_out("R5", O_STAT, pass ? 8'h01 : 8'h00, 1);
        end
        stat_ack = 1; tick(); clear_in();
        expect_out("R5_R6", O_DONE, 8'h00, 0);
        tick(); expect_out("R6", O_IDLE, 8'h00, 0);
    endtask

    task automatic run_diag(bit pass, int dly);
        cmd_diag = 1; tick(); clear_in();
        expect_out("R7", O_DIAG, 8'h00, 0);
        for (int i = 0; i < dly; i++) begin
            cmd_devrst = (i == 0); tick(); clear_in();
            expect_out("R10", O_DIAG, 8'h00, 0);
        end
        diag_done = 1; diag_pass = pass; tick(); clear_in();
        expect_out("R7", O_STAT, pass ? 8'h01 : 8'h00, 1);
        stat_ack = 1; tick(); clear_in();
        expect_out("R7", O_DONE, 8'h00, 0);
        tick(); expect_out("R6", O_IDLE, 8'h00, 0);
    endtask

    task automatic dev_reset(int dly, bit both_cmds);
        cmd_devrst = 1; cmd_diag = both_cmds; tick(); clear_in();
        expect_out("R8", O_HALT, 8'h00, 0);
        for (int i = 0; i < dly; i++) begin
            cmd_diag = 1; tick(); clear_in();
            expect_out("R10", O_HALT, 8'h00, 0);
        end
        quiesced = 1; tick(); clear_in();
        expect_out("R8", O_STAT, 8'h01, 1);
        for (int i = 0; i < dly; i++) begin tick(); expect_out("R8", O_STAT, 8'h01, 1); end
        stat_ack = 1; tick(); clear_in();
        expect_out("R8", O_NONE, 8'h00, 0);
        for (int i = 0; i < dly; i++) begin tick(); expect_out("R8", O_NONE, 8'h00, 0); end
        host_frame = 1; tick(); clear_in();
        expect_out("R8", O_DONE, 8'h00, 0);
        tick(); expect_out("R6", O_IDLE, 8'h00, 0);
    endtask

    initial begin
        clear_in();
        repeat (3) tick();
        rst_n = 1;
        tick();
        expect_out("R1", O_NONE, 8'h00, 0);
        repeat (3) tick();
        expect_out("R2", O_NONE, 8'h00, 0);

        for (int p = 0; p < 2; p++)
            for (int d = 0; d < 4; d++)
                power_up(p[0], d);

        for (int p = 0; p < 2; p++)
            for (int d = 0; d < 4; d++)
                run_diag(p[0], d);

        for (int d = 0; d < 3; d++) dev_reset(d, d == 1);

        // R9: software reset aborts a diagnostic run
        cmd_diag = 1; tick(); clear_in();
        expect_out("R7", O_DIAG, 8'h00, 0);
        soft_rst = 1; diag_done = 1; diag_pass = 1; tick(); clear_in();
        expect_out("R9", O_HALT, 8'h00, 0);
        // R9: software reset restarts from the status request
        quiesced = 1; tick(); clear_in();
        expect_out("R8", O_STAT, 8'h01, 1);
        soft_rst = 1; tick(); clear_in();
        expect_out("R9", O_HALT, 8'h00, 0);
        // R2: line reset preempts the halt
        line_rst = 1; tick(); clear_in();
        expect_out("R2", O_NONE, 8'h00, 0);
        // R2: line reset wins over a same-cycle release
        line_rst = 1; line_rel = 1; tick(); clear_in();
        expect_out("R2", O_NONE, 8'h00, 0);
        // R10: commands ignored in the held-reset state
        cmd_diag = 1; cmd_devrst = 1; tick(); clear_in();
        expect_out("R10", O_NONE, 8'h00, 0);
        power_up(1'b1, 0);
        // R9: software reset from idle
        soft_rst = 1; tick(); clear_in();
        expect_out("R9", O_HALT, 8'h00, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule